// File: doc/BRIEF.md
# Attribute-Masked Control Register Bank

This block is a bank of 32-bit control and status registers behind a simple single-cycle bus port. Each register has an elaboration-time byte address, a reset value, and four per-bit attribute masks. The masks mark a bit as read-only, cleared by writing a one, reserved, or cleared when read. A write merges the incoming data with the stored value. Only bits that are writable and that fall inside the bytes selected by the access size take the new data. Bits in the write-one-to-clear set drop to zero where the data holds a one.

Reads return the stored value masked to the access size. The response comes one cycle after the strobe, together with a valid pulse. Bits in the clear-on-read set that lie inside the read bytes are zeroed in the store as a side effect. An address that matches no register is harmless: a write to it changes nothing and a read from it returns zero. An error pulse flags any access to such an address. It also flags a write that would alter a reserved bit inside the enabled bytes.

Top module: `csr_attr_bank`

## Requirements
- R1: On reset, every register holds its configured reset value, and `bus_rvalid` and `bus_err` are 0.
- R2: On a write to a mapped address, a bit takes the written value when it is inside the enabled bytes and is neither read-only, write-one-to-clear nor reserved. Every other bit keeps its previous value.
- R3: On a write, a write-one-to-clear bit inside the enabled bytes is cleared when the written data holds 1 at that position. Where the data holds 0, the bit is unchanged.
- R4: `bus_size` value 1 enables byte 0 (bits 7:0), value 2 enables bytes 0 and 1 (bits 15:0), and any other value enables all four bytes.
- R5: Read data is the stored value ANDed with the enabled-byte mask, so bytes outside the access size read as zero.
- R6: A read clears the clear-on-read bits inside the enabled bytes, and it returns the value held before the clear. Clear-on-read bits outside the enabled bytes are kept.
- R7: A write to an unmapped address leaves every register unchanged. A read from one returns zero with `bus_rvalid` high.
- R8: `bus_rvalid` is high for exactly the cycle after each cycle with `bus_rd` high, and `bus_rdata` is valid in that same cycle.
- R9: `bus_err` pulses for one cycle, one cycle after an access to an unmapped address. It also pulses after a write whose data differs from the stored value in a reserved bit inside the enabled bytes.
- R10: When `bus_wr` and `bus_rd` hit the same register in one cycle, the read returns the pre-write value. The register then takes the write result, and no clear-on-read clearing takes place.
- R11: A register responds only to its exact configured byte address, which must be word aligned. A non-aligned address, such as base+1, is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid pulse |
| bus_err | output | 1 | Error pulse for unmapped access or reserved-bit change |

## Verification
Every result of this block appears exactly one clock after the strobe that caused it. Read data, the valid pulse and the error pulse come from the response registers. Any change to the stored value first shows in the next read, which answers one further cycle later. The bench's model steps on the same rising edge as the design and records its expected response for the cycle that follows. The outputs are compared on every falling edge, so each comparison falls in the middle of the cycle in which the response is due. The effect of a write or a clear is always observed through a later read, and never read from internal state.

// File: rtl/csr_attr_pkg.sv
package csr_attr_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned WORD_BYTES = WORD_W / 8;

   localparam logic [2:0] SZ_ONE = 3'd1;
   localparam logic [2:0] SZ_TWO = 3'd2;

   typedef logic [WORD_W-1:0] word_t;

   // Enabled-byte mask for an access size; unknown codes mean a full word.
   function automatic word_t size_to_mask(input logic [2:0] sz);
      word_t m;
      case (sz)
         SZ_ONE:  m = word_t'(32'h0000_00FF);
         SZ_TWO:  m = word_t'(32'h0000_FFFF);
         default: m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/csr_attr_decode.sv
module csr_attr_decode #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
      assign sel[i] = (addr == REG_ADDR[i]);
   end

   assign hit = |sel;

endmodule

// File: rtl/csr_attr_cell.sv
module csr_attr_cell
   import csr_attr_pkg::*;
#(
   parameter word_t RESET_VAL = '0,
   parameter word_t RO_MASK   = '0,
   parameter word_t W1C_MASK  = '0,
   parameter word_t RSVD_MASK = '0,
   parameter word_t COR_MASK  = '0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_sel,
   input  logic  rd_sel,
   input  word_t wdata,
   input  word_t en,
   output word_t q,
   output logic  rsvd_viol
);

   word_t guard;
   word_t merged;
   word_t nxt;

   always_comb begin
      guard  = RO_MASK | W1C_MASK | RSVD_MASK | ~en;
      merged = (wdata & ~guard) | (q & guard);
      merged = merged & ~(wdata & W1C_MASK & en);
      if (wr_sel)      nxt = merged;
      else if (rd_sel) nxt = q & ~(COR_MASK & en);
      else             nxt = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= nxt;
   end

   assign rsvd_viol = wr_sel && (((q ^ wdata) & RSVD_MASK & en) != '0);

   // R2
   ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(q & RO_MASK & ~COR_MASK));

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> ((q & $past(wdata & en & W1C_MASK)) == '0));

   // R6
   cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel && !wr_sel) |=> ((q & $past(en) & COR_MASK) == '0));

   // R2
   rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> ((q & RSVD_MASK) == ($past(q) & RSVD_MASK)));

endmodule

// File: rtl/csr_attr_resp.sv
module csr_attr_resp
   import csr_attr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd,
   input  logic                     wr,
   input  logic                     hit,
   input  logic [NUM_REGS-1:0]      sel,
   input  logic [NUM_REGS-1:0][WORD_W-1:0] q,
   input  word_t                    en,
   input  logic                     viol,
   output word_t                    rdata,
   output logic                     rvalid,
   output logic                     err
);

   word_t mux;

   always_comb begin
      mux = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) mux = mux | q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
         err    <= 1'b0;
      end else begin
         rvalid <= rd;
         rdata  <= rd ? (mux & en) : '0;
         err    <= ((rd || wr) && !hit) || viol;
      end
   end

   // R8
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rvalid);

   // R8
   rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rvalid);

   // R7
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !hit) |=> (rdata == '0 && err));

endmodule

// File: rtl/csr_attr_bank.sv
module csr_attr_bank
   import csr_attr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR =
      {8'h10, 8'h08, 8'h04, 8'h00},
   parameter logic [NUM_REGS-1:0][31:0] REG_RESET =
      {32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_FF0F, 32'h0000_00A5},
   parameter logic [NUM_REGS-1:0][31:0] REG_RO =
      {32'hFFFF_0000, 32'h0000_0000, 32'h0000_000F, 32'h0000_0000},
   parameter logic [NUM_REGS-1:0][31:0] REG_W1C =
      {32'h0000_0000, 32'h0000_0000, 32'h0000_FF00, 32'h0000_0000},
   parameter logic [NUM_REGS-1:0][31:0] REG_RSVD =
      {32'h0000_00F0, 32'h0000_0000, 32'h0000_0000, 32'hFF00_0000},
   parameter logic [NUM_REGS-1:0][31:0] REG_COR =
      {32'h0000_000F, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [2:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              bus_err
);

   localparam int unsigned MAX_REGS = 16;
   localparam int unsigned ALIGN_W  = $clog2(WORD_BYTES);

   // Elaboration-time parameter checks
   if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) begin : g_bad_count
      $error("csr_attr_bank: NUM_REGS must lie in 1..16");
   end
   if (ADDR_W <= ALIGN_W) begin : g_bad_addr_w
      $error("csr_attr_bank: ADDR_W too narrow for word addressing");
   end
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_addr_chk
      if (REG_ADDR[i][ALIGN_W-1:0] != '0) begin : g_unaligned
         $error("csr_attr_bank: register address not word aligned");
      end
      for (genvar j = i + 1; j < NUM_REGS; j++) begin : g_dup
         if (REG_ADDR[i] == REG_ADDR[j]) begin : g_same
            $error("csr_attr_bank: two registers share one address");
         end
      end
   end

   logic [NUM_REGS-1:0]             sel;
   logic                            hit;
   logic [NUM_REGS-1:0]             viol;
   logic [NUM_REGS-1:0][WORD_W-1:0] q;
   word_t                           en;

   assign en = size_to_mask(bus_size);

   csr_attr_decode #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR)
   ) i_decode (
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      csr_attr_cell #(
         .RESET_VAL (REG_RESET[i]),
         .RO_MASK   (REG_RO[i]),
         .W1C_MASK  (REG_W1C[i]),
         .RSVD_MASK (REG_RSVD[i]),
         .COR_MASK  (REG_COR[i])
      ) i_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_sel    (bus_wr & sel[i]),
         .rd_sel    (bus_rd & sel[i]),
         .wdata     (bus_wdata),
         .en        (en),
         .q         (q[i]),
         .rsvd_viol (viol[i])
      );
   end

   csr_attr_resp #(
      .NUM_REGS (NUM_REGS)
   ) i_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .hit    (hit),
      .sel    (sel),
      .q      (q),
      .en     (en),
      .viol   (|viol),
      .rdata  (bus_rdata),
      .rvalid (bus_rvalid),
      .err    (bus_err)
   );

   // R5
   narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size == SZ_ONE) |=> (bus_rdata[31:8] == '0));

   // R9
   unmapped_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> bus_err);

   // R9
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !bus_rd) |=> !bus_err);

endmodule

// File: tb/test_csr_attr_bank.sv
`timescale 1ns/1ps
module test_csr_attr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [2:0]  bus_size = 3'd4;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        bus_err;

   always #2.5 clk = ~clk;

   csr_attr_bank i_csr_attr_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_size   (bus_size),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .bus_err    (bus_err)
   );

   // Register table as specified for the default configuration
   localparam logic [7:0]  T_ADDR [4] = '{8'h00, 8'h04, 8'h08, 8'h10};
   localparam logic [31:0] T_RST  [4] = '{32'h0000_00A5, 32'h0000_FF0F, 32'h1234_5678, 32'hDEAD_BEEF};
   localparam logic [31:0] T_RO   [4] = '{32'h0, 32'h0000_000F, 32'h0, 32'hFFFF_0000};
   localparam logic [31:0] T_W1C  [4] = '{32'h0, 32'h0000_FF00, 32'h0, 32'h0};
   localparam logic [31:0] T_RSVD [4] = '{32'hFF00_0000, 32'h0, 32'h0, 32'h0000_00F0};
   localparam logic [31:0] T_COR  [4] = '{32'h0, 32'h0, 32'hFFFF_0000, 32'h0000_000F};

   logic [31:0] m_q [4];
   logic        exp_rvalid = 1'b0;
   logic        exp_err = 1'b0;
   logic [31:0] exp_rdata = '0;
   string       cur_req = "R1";
   string       exp_req = "R1";
   int          vectors = 0;
   int          misses = 0;
   bit          checking = 1'b0;
   bit          finished = 1'b0;

   function automatic logic [31:0] bytes_en(input logic [2:0] sz);
      int n;
      logic [31:0] m;
      n = (sz == 3'd1) ? 1 : (sz == 3'd2) ? 2 : 4;
      m = '0;
      for (int b = 0; b < n; b++) m[b*8 +: 8] = 8'hFF;
      return m;
   endfunction

   // Behavioural reference, stepped on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) m_q[k] = T_RST[k];
         exp_rvalid = 1'b0;
         exp_err    = 1'b0;
         exp_rdata  = '0;
      end else begin
         int          idx;
         logic [31:0] en;
         logic [31:0] old;
         logic [31:0] nw;
         idx = -1;
         for (int k = 0; k < 4; k++) if (T_ADDR[k] == bus_addr) idx = k;
         en         = bytes_en(bus_size);
         exp_rvalid = bus_rd;
         exp_err    = 1'b0;
         exp_rdata  = '0;
         exp_req    = cur_req;
         if ((bus_rd || bus_wr) && idx < 0) exp_err = 1'b1;
         if (idx >= 0) begin
            old = m_q[idx];
            nw  = old;
            if (bus_rd) exp_rdata = old & en;
            if (bus_wr) begin
               for (int b = 0; b < 32; b++) begin
                  if (T_RSVD[idx][b] && en[b] && (old[b] != bus_wdata[b])) exp_err = 1'b1;
                  if (en[b] && !T_RO[idx][b] && !T_W1C[idx][b] && !T_RSVD[idx][b])
                     nw[b] = bus_wdata[b];
                  if (en[b] && T_W1C[idx][b] && bus_wdata[b]) nw[b] = 1'b0;
               end
            end else if (bus_rd) begin
               for (int b = 0; b < 32; b++)
                  if (en[b] && T_COR[idx][b]) nw[b] = 1'b0;
            end
            m_q[idx] = nw;
         end
      end
   end

   // Compare every cycle, mid-cycle
   always @(negedge clk) begin
      if (checking && !finished) begin
         vectors++;
         if (bus_rvalid !== exp_rvalid) begin
            misses++;
            $display("FAIL %s rvalid actual %0b expected %0b", exp_req, bus_rvalid, exp_rvalid);
         end
         if (bus_err !== exp_err) begin
            misses++;
            $display("FAIL %s err actual %0b expected %0b", exp_req, bus_err, exp_err);
         end
         if (exp_rvalid && bus_rdata !== exp_rdata) begin
            misses++;
            $display("FAIL %s rdata actual %08h expected %08h", exp_req, bus_rdata, exp_rdata);
         end
      end
   end

   task automatic op(input bit wr, input bit rd, input logic [7:0] a,
                     input logic [31:0] d, input logic [2:0] sz, input string req);
      @(negedge clk);
      bus_wr    = wr;
      bus_rd    = rd;
      bus_addr  = a;
      bus_wdata = d;
      bus_size  = sz;
      cur_req   = req;
   endtask

   task automatic idle(input string req);
      op(1'b0, 1'b0, 8'h00, 32'h0, 3'd4, req);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         misses++;
         $display("FAIL R8 watchdog actual hung expected completion");
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      checking = 1'b1;
      // R1: reset values and quiet outputs
      idle("R1");
      op(0, 1, 8'h00, 0, 4, "R1");
      op(0, 1, 8'h04, 0, 4, "R1");
      op(0, 1, 8'h10, 0, 1, "R1");
      // R2: writable bits, protected bits kept
      op(1, 0, 8'h00, 32'hFF5A_C33C, 4, "R2");
      op(0, 1, 8'h00, 0, 4, "R2");
      op(1, 0, 8'h10, 32'h0000_1A5A, 4, "R2");
      op(0, 1, 8'h10, 0, 4, "R2");
      op(1, 0, 8'h04, 32'hFFFF_00F0, 4, "R2");
      op(0, 1, 8'h04, 0, 4, "R2");
      // R3: write one to clear
      op(1, 0, 8'h04, 32'h0000_0F00, 4, "R3");
      op(0, 1, 8'h04, 0, 4, "R3");
      op(1, 0, 8'h04, 32'h0000_F000, 2, "R3");
      op(0, 1, 8'h04, 0, 4, "R3");
      // R4: access size enables
      op(1, 0, 8'h00, 32'h00BB_CCDD, 1, "R4");
      op(0, 1, 8'h00, 0, 4, "R4");
      op(1, 0, 8'h00, 32'h0011_2233, 2, "R4");
      op(0, 1, 8'h00, 0, 4, "R4");
      op(1, 0, 8'h00, 32'h0077_8899, 3, "R4");
      op(0, 1, 8'h00, 0, 4, "R4");
      // R5: narrow reads
      op(0, 1, 8'h10, 0, 1, "R5");
      op(0, 1, 8'h10, 0, 2, "R5");
      op(0, 1, 8'h04, 0, 1, "R5");
      // R6: clear on read
      op(0, 1, 8'h08, 0, 2, "R6");
      op(0, 1, 8'h08, 0, 4, "R6");
      op(0, 1, 8'h08, 0, 4, "R6");
      op(0, 1, 8'h10, 0, 1, "R6");
      op(0, 1, 8'h10, 0, 4, "R6");
      // R7: unmapped addresses
      op(1, 0, 8'h0C, 32'hFFFF_FFFF, 4, "R7");
      op(0, 1, 8'h0C, 0, 4, "R7");
      op(0, 1, 8'h40, 0, 4, "R7");
      op(0, 1, 8'h00, 0, 4, "R7");
      op(0, 1, 8'h04, 0, 4, "R7");
      // R11: misaligned addresses are unmapped
      op(1, 0, 8'h01, 32'hFFFF_FFFF, 4, "R11");
      op(0, 1, 8'h05, 0, 4, "R11");
      op(0, 1, 8'h00, 0, 4, "R11");
      // R9: reserved changes outside/inside enabled bytes
      op(1, 0, 8'h00, 32'h5500_0001, 1, "R9");
      op(1, 0, 8'h00, 32'h5500_0001, 4, "R9");
      op(1, 0, 8'h10, 32'h0000_00F0, 1, "R9");
      idle("R9");
      // R10: simultaneous write and read on one register
      op(1, 0, 8'h08, 32'hABCD_1234, 4, "R10");
      op(1, 1, 8'h08, 32'h5555_AAAA, 4, "R10");
      op(0, 1, 8'h08, 0, 4, "R10");
      op(0, 1, 8'h08, 0, 4, "R10");
      // R8: back-to-back and isolated reads
      op(0, 1, 8'h00, 0, 4, "R8");
      op(0, 1, 8'h04, 0, 4, "R8");
      idle("R8");
      op(0, 1, 8'h10, 0, 2, "R8");
      idle("R8");
      idle("R8");
      // R2: mixed traffic
      for (int n = 0; n < 400; n++) begin
         logic [7:0]  a;
         logic [2:0]  s;
         int unsigned pick;
         pick = $urandom_range(0, 5);
         case (pick)
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08;
            3: a = 8'h10; 4: a = 8'h0C; default: a = 8'h11;
         endcase
         pick = $urandom_range(0, 3);
         s = (pick == 0) ? 3'd1 : (pick == 1) ? 3'd2 : (pick == 2) ? 3'd4 : 3'd7;
         op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom(), s, "R2");
      end
      idle("R2");
      idle("R2");
      @(negedge clk);
      @(posedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule